// File: doc/BRIEF.md
# Phase-Tracking Reusable Arrival Barrier

This block is a reusable synchronization barrier shared by the requesters of one compute cluster. It holds an arrival counter, a programmed goal for that counter, a pending byte balance and a single phase bit. Software programs the goal once through the setup port. After that, every cycle can deliver arrivals on several arrive ports at once, and each port is tagged as coming from the local unit or from the peer unit. An arrive may also announce a number of bytes still to come, and a separate landing port subtracts bytes as the data lands.

A round closes when the summed arrivals reach the goal while the byte balance is zero. Closing a round clears the counter, flips the phase and emits a one-cycle pulse. Requesters never block inside the barrier. Each one presents the phase it last observed and reads back a ready bit that is high only while the barrier phase differs from that value. A requester that inverts its own tracked phase after every round can therefore reuse the same barrier indefinitely. A requester that always presents 0 drifts out of step after the first round.

In a typical configuration two units of 128 requesters each arrive once locally and once on the peer, which gives a goal of 256 per round.

Top module: `phase_barrier`

## Requirements
- R1: After reset the phase is 0, the completion pulse is low, both error flags are low, and every `waitReady` bit equals `barPhase != waitPhase[i]`.
- R2: A setup strobe loads the goal from `setupCount`, clears the counter and byte balance, and forces the phase to 0 on the next edge. Arrives in a setup cycle are not counted. The goal must be at least 1.
- R3: All asserted `arriveValid` bits of one cycle add to the counter in that cycle. When the new total reaches the goal with a zero byte balance, the counter returns to 0, the phase toggles, and `roundDone` is high for exactly the following cycle.
- R4: If the total of one cycle passes the goal, the barrier completes exactly once and the sticky `overflowErr` flag rises on the same edge.
- R5: `waitReady[i]` is combinational and is 1 exactly when `barPhase` differs from `waitPhase[i]`.
- R6: Port p's byte field is `arriveBytes[p*BYTE_W +: BYTE_W]` and is added to the byte balance when that port arrives. `landBytes` is subtracted when `landValid` is high. Completion needs the arrival goal and a zero balance in the same cycle.
- R7: The `arrivePeer` tag does not change the counting. A round made only of peer arrives completes like a round made of local arrives.
- R8: An arrive before the first setup is ignored and sets the sticky `earlyArriveErr` flag.
- R9: A requester that inverts its tracked phase after each round sees ready after each of at least three rounds. A requester that always presents phase 0 sees no ready once the second round has closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setupValid | input | 1 | Load a new arrival goal |
| setupCount | input | CNT_W | Arrival goal per round (at least 1) |
| arriveValid | input | NUM_PORTS | One arrive per set bit |
| arrivePeer | input | NUM_PORTS | Arrive comes from the peer unit (tag only) |
| arriveBytes | input | NUM_PORTS*BYTE_W | Bytes each arriving port announces |
| landValid | input | 1 | Landing report present |
| landBytes | input | BYTE_W | Bytes landed this cycle |
| waitPhase | input | NUM_WAITERS | Phase each requester last observed |
| waitReady | output | NUM_WAITERS | Barrier phase differs from the presented phase |
| barPhase | output | 1 | Current phase bit |
| roundDone | output | 1 | One-cycle pulse per phase flip |
| overflowErr | output | 1 | Sticky: arrivals passed the goal |
| earlyArriveErr | output | 1 | Sticky: arrive seen before setup |

## Verification
The final arrival of a round and the final byte landing can fall in the same cycle, and so can several port arrivals that together pass the goal. The bench drives the last arrive together with the landing report that zeroes the balance. It checks that the phase flips on that one edge, and it checks that an otherwise identical cycle with a short landing leaves the phase alone. It also drives multi-port bursts that pass the goal, and judges them by a single flip together with the overflow flag.

// File: rtl/phase_barrier_pkg.sv
`timescale 1ns/1ps
package phase_barrier_pkg;
  typedef struct packed {
    logic loadSetup;  // program goal, clear round state
    logic accept;     // arrivals and bytes of this cycle are absorbed
    logic complete;   // round closes on this edge
  } ctrlStrobes_t;
endpackage

// File: rtl/phase_barrier_dp.sv
`timescale 1ns/1ps
module phase_barrier_dp
  import phase_barrier_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 9,
  parameter int BYTE_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrlStrobes_t                strobes,
  input  logic [CNT_W-1:0]            setupCount,
  input  logic [NUM_PORTS-1:0]        arriveValid,
  input  logic [NUM_PORTS-1:0]        arrivePeer,
  input  logic [NUM_PORTS*BYTE_W-1:0] arriveBytes,
  input  logic                        landValid,
  input  logic [BYTE_W-1:0]           landBytes,
  output logic                        goalMet,
  output logic                        excess
);
  localparam int SUM_W  = CNT_W + 1;
  localparam int PEND_W = BYTE_W + $clog2(NUM_PORTS) + 2;

  logic [CNT_W-1:0]  count, goal;
  logic [PEND_W-1:0] pend;
  logic [SUM_W-1:0]  arriveSum, newCount;
  logic [PEND_W-1:0] byteSum, landExt, newPend;
  logic [BYTE_W-1:0] portBytes [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack
    assign portBytes[p] = arriveValid[p] ? arriveBytes[p*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    arriveSum = '0;
    byteSum   = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      arriveSum = arriveSum + SUM_W'(arriveValid[p]);
      byteSum   = byteSum + PEND_W'(portBytes[p]);
    end
    landExt  = landValid ? PEND_W'(landBytes) : '0;
    newCount = SUM_W'(count) + arriveSum;
    newPend  = pend + byteSum - landExt;
    goalMet  = (newCount != '0) && (newCount >= SUM_W'(goal)) && (newPend == '0);
    excess   = newCount > SUM_W'(goal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      goal  <= CNT_W'(1);
      pend  <= '0;
    end else if (strobes.loadSetup) begin
      count <= '0;
      goal  <= setupCount;
      pend  <= '0;
    end else if (strobes.accept) begin
      count <= strobes.complete ? '0 : newCount[CNT_W-1:0];
      pend  <= newPend;
    end
  end

  // R6: a closed round leaves no byte balance behind
  a_r6_balance_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.complete |=> (pend == '0));
  // R3: the counter sits at or past the goal only while bytes are still owed
  a_r3_count_below_goal: assert property (@(posedge clk) disable iff (!rst_n)
    (count < goal) || (pend != '0));
  // R7: peer-tagged arrivals grow the counter by their number
  a_r7_peer_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.accept && !strobes.complete && |(arriveValid & arrivePeer))
      |=> (SUM_W'(count) == $past(SUM_W'(count)) + $past(SUM_W'($countones(arriveValid)))));
endmodule

// File: rtl/phase_barrier_ctrl.sv
`timescale 1ns/1ps
module phase_barrier_ctrl
  import phase_barrier_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         setupValid,
  input  logic         anyArrive,
  input  logic         goalMet,
  input  logic         excess,
  output ctrlStrobes_t strobes,
  output logic         barPhase,
  output logic         roundDone,
  output logic         overflowErr,
  output logic         earlyArriveErr
);
  logic setupDone;

  always_comb begin
    strobes.loadSetup = setupValid;
    strobes.accept    = setupDone && !setupValid;
    strobes.complete  = setupDone && !setupValid && goalMet;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setupDone      <= 1'b0;
      barPhase       <= 1'b0;
      roundDone      <= 1'b0;
      overflowErr    <= 1'b0;
      earlyArriveErr <= 1'b0;
    end else begin
      setupDone <= setupDone | setupValid;
      if (strobes.loadSetup)     barPhase <= 1'b0;
      else if (strobes.complete) barPhase <= ~barPhase;
      roundDone      <= strobes.complete;
      overflowErr    <= overflowErr | (strobes.complete & excess);
      earlyArriveErr <= earlyArriveErr | (!setupDone & anyArrive);
    end
  end

  // R3: every phase change not caused by setup comes with the pulse
  a_r3_flip_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    ((barPhase != $past(barPhase)) && !$past(setupValid)) |-> roundDone);
  // R4: passing the goal is always reported
  a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.complete && excess) |=> overflowErr);
  // R8: arrivals before setup raise the flag
  a_r8_early_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!setupDone && anyArrive) |=> earlyArriveErr);
  // R8: no round can close before setup
  a_r8_no_early_round: assert property (@(posedge clk) disable iff (!rst_n)
    !setupDone |=> !roundDone);
endmodule

// File: rtl/phase_barrier.sv
`timescale 1ns/1ps
module phase_barrier
  import phase_barrier_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int NUM_WAITERS = 4,
  parameter int CNT_W       = 9,
  parameter int BYTE_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        setupValid,
  input  logic [CNT_W-1:0]            setupCount,
  input  logic [NUM_PORTS-1:0]        arriveValid,
  input  logic [NUM_PORTS-1:0]        arrivePeer,
  input  logic [NUM_PORTS*BYTE_W-1:0] arriveBytes,
  input  logic                        landValid,
  input  logic [BYTE_W-1:0]           landBytes,
  input  logic [NUM_WAITERS-1:0]      waitPhase,
  output logic [NUM_WAITERS-1:0]      waitReady,
  output logic                        barPhase,
  output logic                        roundDone,
  output logic                        overflowErr,
  output logic                        earlyArriveErr
);
  ctrlStrobes_t strobes;
  logic goalMet, excess;

  phase_barrier_dp #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .setupCount(setupCount),
    .arriveValid(arriveValid), .arrivePeer(arrivePeer), .arriveBytes(arriveBytes),
    .landValid(landValid), .landBytes(landBytes), .goalMet(goalMet), .excess(excess));

  phase_barrier_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .setupValid(setupValid), .anyArrive(|arriveValid),
    .goalMet(goalMet), .excess(excess), .strobes(strobes), .barPhase(barPhase),
    .roundDone(roundDone), .overflowErr(overflowErr), .earlyArriveErr(earlyArriveErr));

  for (genvar w = 0; w < NUM_WAITERS; w++) begin : g_wait
    assign waitReady[w] = barPhase ^ waitPhase[w];
  end

  // R5: a requester presenting the current phase is never told ready
  a_r5_stall_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (waitPhase[0] == barPhase) |-> !waitReady[0]);
endmodule

// File: tb/phase_barrier_tb_top.sv
`timescale 1ns/1ps
module phase_barrier_tb_top;
  localparam int NP = 4, NW = 4, CW = 9, BW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic setupValid = 1'b0;
  logic [CW-1:0] setupCount = '0;
  logic [NP-1:0] arriveValid = '0, arrivePeer = '0;
  logic [NP*BW-1:0] arriveBytes = '0;
  logic landValid = 1'b0;
  logic [BW-1:0] landBytes = '0;
  logic [NW-1:0] waitPhase = '0, waitReady;
  logic barPhase, roundDone, overflowErr, earlyArriveErr;

  phase_barrier #(.NUM_PORTS(NP), .NUM_WAITERS(NW), .CNT_W(CW), .BYTE_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .setupValid(setupValid), .setupCount(setupCount),
    .arriveValid(arriveValid), .arrivePeer(arrivePeer), .arriveBytes(arriveBytes),
    .landValid(landValid), .landBytes(landBytes), .waitPhase(waitPhase),
    .waitReady(waitReady), .barPhase(barPhase), .roundDone(roundDone),
    .overflowErr(overflowErr), .earlyArriveErr(earlyArriveErr));

  always #2.5 clk = ~clk;

  int vecs = 0, bad = 0;
  bit finished = 1'b0;
  // bench model of the requirements
  int  mGoal = 1, mCount = 0, mPend = 0;
  bit  mPhase = 0, mInit = 0, mOv = 0, mEarly = 0, mDone = 0;
  bit  trk = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "barPhase", barPhase, mPhase);
    chk(tag, "roundDone", roundDone, mDone);
    chk(tag, "overflowErr", overflowErr, mOv);
    chk(tag, "earlyArriveErr", earlyArriveErr, mEarly);
    for (int w = 0; w < NW; w++) chk(tag, "waitReady", waitReady[w], mPhase != waitPhase[w]);
  endtask

  // one cycle: drive at negedge, sample 1 ns after the posedge
  task automatic step(input bit su, input int sc, input logic [NP-1:0] av,
                      input logic [NP-1:0] pr, input logic [NP*BW-1:0] by,
                      input bit lv, input int lb, input string tag);
    int nc, np, bsum;
    @(negedge clk);
    setupValid = su; setupCount = CW'(sc); arriveValid = av; arrivePeer = pr;
    arriveBytes = by; landValid = lv; landBytes = BW'(lb);
    waitPhase[0] = trk;
    mDone = 0;
    if (!mInit && av != 0) mEarly = 1;
    if (su) begin
      mGoal = sc; mCount = 0; mPend = 0; mPhase = 0; mInit = 1;
    end else if (mInit) begin
      bsum = 0;
      for (int p = 0; p < NP; p++) if (av[p]) bsum += int'(by[p*BW +: BW]);
      nc = mCount + $countones(av);
      np = mPend + bsum - (lv ? lb : 0);
      if (nc != 0 && nc >= mGoal && np == 0) begin
        mDone = 1; if (nc > mGoal) mOv = 1;
        mPhase = ~mPhase; mCount = 0; mPend = 0;
      end else begin
        mCount = nc; mPend = np;
      end
    end
    @(posedge clk); #1;
    checkAll(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, '0, '0, 0, 0, tag);
  endtask

  function automatic logic [NP*BW-1:0] onePort(input int p, input int b);
    logic [NP*BW-1:0] v = '0;
    v[p*BW +: BW] = BW'(b);
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    int guard;
    waitPhase = 4'b1000;  // waiter1 hardcoded 0, waiter2 0, waiter3 1
    #12; @(negedge clk); #1;
    checkAll("R1");           // reset state under reset
    rst_n = 1'b1;
    idle("R1");

    // R8: arrivals before setup are ignored and flagged
    step(0, 0, 4'b0011, 4'b0000, '0, 0, 0, "R8");
    idle("R8");

    // R2: setup clears state; goal 3
    step(1, 3, 4'b1111, '0, '0, 0, 0, "R2");
    step(0, 0, 4'b0011, '0, '0, 0, 0, "R2");
    chk("R2", "no flip at 2 of 3", barPhase, 0);
    // R3: multi-port completion, pulse lasts one cycle
    step(0, 0, 4'b0100, '0, '0, 0, 0, "R3");
    chk("R3", "flip at goal", barPhase, 1);
    if (mDone) trk = ~trk;
    idle("R3");
    chk("R3", "pulse one cycle", roundDone, 0);

    // R2: setup while phase is 1 returns phase to 0
    step(1, 2, '0, '0, '0, 0, 0, "R2");
    chk("R2", "phase reset by setup", barPhase, 0);
    trk = 0;

    // R4: burst passing the goal
    step(0, 0, 4'b1111, '0, '0, 0, 0, "R4");
    chk("R4", "overflow flagged", overflowErr, 1);
    idle("R4");
    chk("R4", "single flip", barPhase, 1);
    trk = 1;

    // R7: peer-only round, goal 4
    step(1, 4, '0, '0, '0, 0, 0, "R7");
    trk = 0;
    step(0, 0, 4'b0011, 4'b0011, '0, 0, 0, "R7");
    step(0, 0, 4'b1100, 4'b1100, '0, 0, 0, "R7");
    chk("R7", "peer round closes", roundDone, 1);
    trk = 1;

    // R6: bytes must land; goal 2
    step(1, 2, '0, '0, '0, 0, 0, "R6");
    trk = 0;
    step(0, 0, 4'b0001, '0, onePort(0, 100), 0, 0, "R6");
    step(0, 0, 4'b0010, '0, '0, 1, 60, "R6");
    chk("R6", "held by byte balance", barPhase, 0);
    step(0, 0, '0, '0, '0, 1, 40, "R6");
    chk("R6", "closes when bytes land", barPhase, 1);
    trk = 1;
    // R6: last arrive and last landing in one cycle; then a short landing
    step(0, 0, 4'b0100, '0, onePort(2, 50), 0, 0, "R6");
    step(0, 0, 4'b1000, '0, '0, 1, 49, "R6");
    chk("R6", "short landing holds", barPhase, 1);
    step(0, 0, '0, '0, '0, 1, 1, "R6");
    chk("R6", "final byte closes", barPhase, 0);
    trk = 0;
    step(0, 0, 4'b0001, '0, onePort(0, 7), 0, 0, "R6");
    step(0, 0, 4'b0010, '0, '0, 1, 7, "R6");
    chk("R6", "arrive and land same cycle", roundDone, 1);
    trk = 1;

    // R9 and R5: sweep goals, three rounds each, tracked vs hardcoded phase
    for (int g = 1; g <= 8; g++) begin
      step(1, g, '0, '0, '0, 0, 0, "R2");
      trk = 0;
      for (int r = 0; r < 3; r++) begin
        guard = 0;
        mDone = 0;
        while (!mDone && guard < 50) begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          step(0, 0, lfsr[3:0] & ((mCount + 1 >= g) ? 4'b0001 : 4'b1111),
               lfsr[7:4], '0, 0, 0, "R9");
          guard++;
        end
        chk("R9", "round completed", mDone, 1);
        chk("R9", "tracked waiter ready", waitReady[0], 1);
        if (r == 1) chk("R9", "hardcoded 0 stalls after round 2", waitReady[1], 0);
        trk = ~trk;
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule